// File: doc/BRIEF.md
# Interrupt-Capable General-Purpose I/O Bank

This block is one bank of general-purpose pins behind a small register bus. Every register is one word wide with one bit per pin. Each pin has three output-side controls: a direction bit, an output data bit and an alternate-function select. Its input level can always be read back through a two-flop synchroniser.

Every pin can also raise an interrupt. A per-pin type bit picks edge or level detection. Two further per-pin bits give the polarity: one sets the edge direction and the other sets the active level. Detected events land in a sticky status register. Software acknowledges events by writing that register: a 0 in a bit position clears it, so writing zero clears everything.

Two per-pin masks decide which latched events reach the outputs. The interrupt mask controls the summary interrupt and the sleep mask controls the wake output. A mask bit of 1 blocks the pin. To get interrupts on both edges, software flips the pin's edge-polarity bit after each event.

Top module: `gpio_trig_bank`

## Requirements
- R1: After reset all pins are inputs (`pin_oe` = 0), the output and alternate registers are 0, the status register reads 0, and both mask registers read all ones. The trigger-type, edge-polarity and level-polarity registers reset to all ones (rising-edge mode). `irq_o` and `wake_o` are 0.
- R2: Register addresses are: 0 direction, 1 output data, 2 alternate select, 3 pin level (read only), 4 trigger type, 5 edge polarity, 6 level polarity, 7 interrupt mask, 8 sleep mask, 9 status. A write is `bus_sel`=1 with `bus_wr`=1 and takes effect at that clock edge. `pin_oe`, `pin_out` and `pin_alt` show the direction, output and alternate registers.
- R3: Reading address 3 returns `pin_in` as it stood before the last two clock edges, through two synchroniser stages.
- R4: A pin whose trigger-type bit is 1 and whose edge-polarity bit is 1 sets its status bit on a 0-to-1 change of its synchronised input. The bit is visible on the third clock edge after the input changes.
- R5: A pin whose trigger-type bit is 1 and whose edge-polarity bit is 0 sets its status bit on a 1-to-0 change of its synchronised input. A rising change has no effect on that pin.
- R6: A pin whose trigger-type bit is 0 sets its status bit on every cycle its synchronised input equals its level-polarity bit. It therefore sets again right after a clear while that level persists.
- R7: A write to the status register keeps only the bits written as 1, so writing 0 clears all bits. An event detected in the same cycle still sets its bit.
- R8: `irq_o` is 1 exactly when some status bit is 1 and that pin's interrupt-mask bit is 0.
- R9: `wake_o` is 1 exactly when some status bit is 1 and that pin's sleep-mask bit is 0.
- R10: A status bit, once set, stays set until a status write clears it, even after its input returns to the idle level.
- R11: Writes to address 3 and to addresses 10 to 15 change no state. Reads of addresses 10 to 15 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational from address |
| pin_in | input | 16 | Raw pin levels from the pads |
| pin_out | output | 16 | Output data for the pads |
| pin_oe | output | 16 | Per-pin output enable (1 = output) |
| pin_alt | output | 16 | Per-pin alternate-function select |
| irq_o | output | 1 | Summary interrupt |
| wake_o | output | 1 | Wake request |

## Verification
A stale synchroniser or edge-history flop would show up in two ways: a pin-level read one cycle early or late, or a status bit appearing one edge off its three-edge latency. A wrong trigger or polarity decode sets status bits on the wrong pins. That error reaches `irq_o` or `wake_o` on the very next edge, provided the mask is open. A status register that loses or gains bits differs from the bench model on the next status read or summary sample. The bench samples `irq_o` and `wake_o` on every cycle and reads the status word every few cycles.

// File: rtl/gpio_trig_pkg.sv
package gpio_trig_pkg;
   localparam int ADDR_W = 4;
   localparam logic [ADDR_W-1:0] ADR_DIR   = 4'd0;
   localparam logic [ADDR_W-1:0] ADR_DOUT  = 4'd1;
   localparam logic [ADDR_W-1:0] ADR_ALT   = 4'd2;
   localparam logic [ADDR_W-1:0] ADR_PIN   = 4'd3;
   localparam logic [ADDR_W-1:0] ADR_TTYPE = 4'd4;
   localparam logic [ADDR_W-1:0] ADR_EPOL  = 4'd5;
   localparam logic [ADDR_W-1:0] ADR_LPOL  = 4'd6;
   localparam logic [ADDR_W-1:0] ADR_IMASK = 4'd7;
   localparam logic [ADDR_W-1:0] ADR_WMASK = 4'd8;
   localparam logic [ADDR_W-1:0] ADR_ISTAT = 4'd9;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
   parameter int WIDTH  = 16,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("gpio_sync needs at least two stages");
   end

   logic [WIDTH-1:0] chain_q [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q[0] <= '0;
      else        chain_q[0] <= d_i;
   end

   for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain_q[s] <= '0;
         else        chain_q[s] <= chain_q[s-1];
      end
   end

   assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/gpio_trig_detect.sv
module gpio_trig_detect (
   input  logic clk,
   input  logic rst_n,
   input  logic level_i,
   input  logic is_edge_i,
   input  logic rise_i,
   input  logic act_high_i,
   output logic event_o
);
   logic prev_q;
   logic edge_hit;
   logic level_hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= level_i;
   end

   always_comb begin
      if (rise_i) edge_hit = level_i & ~prev_q;
      else        edge_hit = ~level_i & prev_q;
      level_hit = (level_i == act_high_i);
      event_o   = is_edge_i ? edge_hit : level_hit;
   end
endmodule

// File: rtl/gpio_trig_bank.sv
module gpio_trig_bank
   import gpio_trig_pkg::*;
#(
   parameter int DATA_W      = 16,
   parameter int NUM_PINS    = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic [NUM_PINS-1:0] pin_in,
   output logic [NUM_PINS-1:0] pin_out,
   output logic [NUM_PINS-1:0] pin_oe,
   output logic [NUM_PINS-1:0] pin_alt,
   output logic              irq_o,
   output logic              wake_o
);
   localparam logic [NUM_PINS-1:0] ALL_ONES = {NUM_PINS{1'b1}};

   if (NUM_PINS < 1 || NUM_PINS > DATA_W) begin : g_bad_pins
      $error("NUM_PINS must be between 1 and DATA_W");
   end

   logic [NUM_PINS-1:0] dir_q, dout_q, alt_q;
   logic [NUM_PINS-1:0] ttype_q, epol_q, lpol_q;
   logic [NUM_PINS-1:0] imask_q, wmask_q, istat_q;
   logic [NUM_PINS-1:0] sync_lvl;
   logic [NUM_PINS-1:0] ev;
   logic [NUM_PINS-1:0] wr_bits;
   logic                wr_en;

   gpio_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d_i(pin_in), .q_o(sync_lvl)
   );

   for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
      gpio_trig_detect u_det (
         .clk(clk), .rst_n(rst_n),
         .level_i(sync_lvl[p]),
         .is_edge_i(ttype_q[p]),
         .rise_i(epol_q[p]),
         .act_high_i(lpol_q[p]),
         .event_o(ev[p])
      );
   end

   assign wr_en   = bus_sel & bus_wr;
   assign wr_bits = bus_wdata[NUM_PINS-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dir_q   <= '0;
         dout_q  <= '0;
         alt_q   <= '0;
         ttype_q <= ALL_ONES;
         epol_q  <= ALL_ONES;
         lpol_q  <= ALL_ONES;
         imask_q <= ALL_ONES;
         wmask_q <= ALL_ONES;
      end else if (wr_en) begin
         case (bus_addr)
            ADR_DIR:   dir_q   <= wr_bits;
            ADR_DOUT:  dout_q  <= wr_bits;
            ADR_ALT:   alt_q   <= wr_bits;
            ADR_TTYPE: ttype_q <= wr_bits;
            ADR_EPOL:  epol_q  <= wr_bits;
            ADR_LPOL:  lpol_q  <= wr_bits;
            ADR_IMASK: imask_q <= wr_bits;
            ADR_WMASK: wmask_q <= wr_bits;
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         istat_q <= '0;
      end else if (wr_en && bus_addr == ADR_ISTAT) begin
         istat_q <= (istat_q & wr_bits) | ev;
      end else begin
         istat_q <= istat_q | ev;
      end
   end

   always_comb begin
      bus_rdata = '0;
      case (bus_addr)
         ADR_DIR:   bus_rdata[NUM_PINS-1:0] = dir_q;
         ADR_DOUT:  bus_rdata[NUM_PINS-1:0] = dout_q;
         ADR_ALT:   bus_rdata[NUM_PINS-1:0] = alt_q;
         ADR_PIN:   bus_rdata[NUM_PINS-1:0] = sync_lvl;
         ADR_TTYPE: bus_rdata[NUM_PINS-1:0] = ttype_q;
         ADR_EPOL:  bus_rdata[NUM_PINS-1:0] = epol_q;
         ADR_LPOL:  bus_rdata[NUM_PINS-1:0] = lpol_q;
         ADR_IMASK: bus_rdata[NUM_PINS-1:0] = imask_q;
         ADR_WMASK: bus_rdata[NUM_PINS-1:0] = wmask_q;
         ADR_ISTAT: bus_rdata[NUM_PINS-1:0] = istat_q;
         default:   bus_rdata = '0;
      endcase
   end

   assign pin_oe  = dir_q;
   assign pin_out = dout_q;
   assign pin_alt = alt_q;
   assign irq_o   = |(istat_q & ~imask_q);
   assign wake_o  = |(istat_q & ~wmask_q);
endmodule

// File: rtl/gpio_trig_bank_chk.sv
module gpio_trig_bank_chk
   import gpio_trig_pkg::*;
#(
   parameter int DATA_W   = 16,
   parameter int NUM_PINS = 16
) (
   input logic                clk,
   input logic                rst_n,
   input logic                bus_sel,
   input logic                bus_wr,
   input logic [ADDR_W-1:0]   bus_addr,
   input logic [DATA_W-1:0]   bus_wdata,
   input logic [NUM_PINS-1:0] pin_oe,
   input logic                irq_o,
   input logic                wake_o,
   input logic [NUM_PINS-1:0] ev,
   input logic [NUM_PINS-1:0] istat,
   input logic [NUM_PINS-1:0] imask,
   input logic [NUM_PINS-1:0] wmask
);
   logic wr_stat, wr_dir;
   assign wr_stat = bus_sel && bus_wr && bus_addr == ADR_ISTAT;
   assign wr_dir  = bus_sel && bus_wr && bus_addr == ADR_DIR;

   a_r1_reset_clears: assert property (@(posedge clk)
      !rst_n |=> (istat == '0 && pin_oe == '0));

   a_r2_dir_write: assert property (@(posedge clk) disable iff (!rst_n)
      wr_dir |=> pin_oe == $past(bus_wdata[NUM_PINS-1:0]));

   a_r4_event_latches: assert property (@(posedge clk) disable iff (!rst_n)
      (ev != '0) |=> ((istat & $past(ev)) == $past(ev)));

   a_r10_status_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_stat |=> ((istat & $past(istat)) == $past(istat)));

   a_r7_zero_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stat && bus_wdata[NUM_PINS-1:0] == '0 && ev == '0) |=> istat == '0);

   a_r8_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      ((istat & ~imask) == '0) |-> !irq_o);

   a_r9_sleep_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      ((istat & ~wmask) == '0) |-> !wake_o);
endmodule

bind gpio_trig_bank gpio_trig_bank_chk #(.DATA_W(DATA_W), .NUM_PINS(NUM_PINS)) chk_i (
   .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
   .bus_addr(bus_addr), .bus_wdata(bus_wdata), .pin_oe(pin_oe),
   .irq_o(irq_o), .wake_o(wake_o), .ev(ev), .istat(istat_q),
   .imask(imask_q), .wmask(wmask_q)
);

// File: tb/gpio_trig_bank_tb_top.sv
module gpio_trig_bank_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0, bus_wr = 1'b0;
   logic [3:0]  bus_addr = '0;
   logic [15:0] bus_wdata = '0, bus_rdata;
   logic [15:0] pin_in = '0, pin_out, pin_oe, pin_alt;
   logic        irq_o, wake_o;

   int n_chk = 0, n_fail = 0;
   bit done = 1'b0;

   // bench model of the requirements
   logic [15:0] m_dir = '0, m_dout = '0, m_alt = '0;
   logic [15:0] m_tt = '1, m_ep = '1, m_lp = '1, m_im = '1, m_wm = '1, m_st = '0;
   logic [15:0] m_s1 = '0, m_s2 = '0, m_prev = '0;

   always #10 clk = ~clk;

   gpio_trig_bank dut_i (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .pin_alt(pin_alt),
      .irq_o(irq_o), .wake_o(wake_o)
   );

   function automatic logic [15:0] exp_events(logic [15:0] s, p, tt, ep, lp);
      return (tt & ((ep & s & ~p) | (~ep & ~s & p))) | (~tt & ((lp & s) | (~lp & ~s)));
   endfunction

   task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // one clock with an optional write; model advances as at the edge
   task automatic cyc(input logic wr, input logic [3:0] a, input logic [15:0] d);
      logic [15:0] e;
      bus_sel = wr; bus_wr = wr; bus_addr = a; bus_wdata = d;
      e = exp_events(m_s2, m_prev, m_tt, m_ep, m_lp);
      if (wr && a == 4'd9) m_st = (m_st & d) | e;
      else                 m_st = m_st | e;
      if (wr) begin
         case (a)
            4'd0: m_dir = d;  4'd1: m_dout = d; 4'd2: m_alt = d;
            4'd4: m_tt = d;   4'd5: m_ep = d;   4'd6: m_lp = d;
            4'd7: m_im = d;   4'd8: m_wm = d;
            default: ;
         endcase
      end
      m_prev = m_s2; m_s2 = m_s1; m_s1 = pin_in;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) cyc(1'b0, 4'd0, 16'h0);
   endtask

   task automatic rd(input logic [3:0] a, output logic [15:0] v);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
      #2 v = bus_rdata;
      bus_sel = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual %h expected %h", 16'h0, 16'h1);
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      logic [15:0] v;
      void'($urandom(32'h5eed_0042));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      rd(4'd9, v); chk("R1 status", v, 16'h0000);
      rd(4'd0, v); chk("R1 direction", v, 16'h0000);
      rd(4'd7, v); chk("R1 irq mask", v, 16'hFFFF);
      rd(4'd8, v); chk("R1 sleep mask", v, 16'hFFFF);
      rd(4'd4, v); chk("R1 trigger type", v, 16'hFFFF);
      chk("R1 pin_oe", pin_oe, 16'h0000);
      chk("R1 irq/wake", {14'h0, irq_o, wake_o}, 16'h0);

      // R2 output side
      cyc(1'b1, 4'd0, 16'h00F0);
      cyc(1'b1, 4'd1, 16'h1234);
      cyc(1'b1, 4'd2, 16'h0F00);
      chk("R2 pin_oe", pin_oe, 16'h00F0);
      chk("R2 pin_out", pin_out, 16'h1234);
      chk("R2 pin_alt", pin_alt, 16'h0F00);
      rd(4'd0, v); chk("R2 direction readback", v, 16'h00F0);

      // R3 sync latency, R4 rising edges
      pin_in = 16'hA5A4;
      idle(1); rd(4'd3, v); chk("R3 pin level after 1 edge", v, 16'h0000);
      rd(4'd9, v); chk("R4 no status after 1 edge", v, 16'h0000);
      idle(1); rd(4'd3, v); chk("R3 pin level after 2 edges", v, 16'hA5A4);
      rd(4'd9, v); chk("R4 no status after 2 edges", v, 16'h0000);
      idle(1); rd(4'd9, v); chk("R4 rising latched", v, 16'hA5A4);
      chk("R8 masked irq", {15'h0, irq_o}, 16'h0);

      // R7 partial and full clear
      cyc(1'b1, 4'd9, 16'hFF00); rd(4'd9, v); chk("R7 partial clear", v, 16'hA500);
      cyc(1'b1, 4'd9, 16'h0000); rd(4'd9, v); chk("R7 zero clears all", v, 16'h0000);

      // R8 / R9 masks
      cyc(1'b1, 4'd7, 16'hFFFE);
      pin_in = 16'hA5A5;
      idle(2); chk("R8 irq before latch", {15'h0, irq_o}, 16'h0);
      idle(1); chk("R8 irq unmasked", {15'h0, irq_o}, 16'h1);
      chk("R9 wake blocked", {15'h0, wake_o}, 16'h0);
      cyc(1'b1, 4'd8, 16'hFFFE); chk("R9 wake open", {15'h0, wake_o}, 16'h1);
      cyc(1'b1, 4'd7, 16'hFFFF); chk("R8 irq remasked", {15'h0, irq_o}, 16'h0);

      // R5 falling edge
      cyc(1'b1, 4'd5, 16'hFFFE);
      cyc(1'b1, 4'd9, 16'h0000);
      pin_in = 16'hA5A4;
      idle(2); rd(4'd9, v); chk("R5 before fall latch", v, 16'h0000);
      idle(1); rd(4'd9, v); chk("R5 falling latched", v, 16'h0001);

      // R10 sticky, and rising ignored in falling mode (R5)
      pin_in = 16'hA5A5;
      idle(3); rd(4'd9, v); chk("R10 status held after rise", v, 16'h0001);

      // R6 level mode
      cyc(1'b1, 4'd9, 16'h0000);
      cyc(1'b1, 4'd4, 16'hFFFD);
      pin_in = 16'hA5A7;
      idle(3); rd(4'd9, v); chk("R6 level high latched", v, 16'h0002);
      cyc(1'b1, 4'd9, 16'h0000); rd(4'd9, v); chk("R6 resets while active", v, 16'h0002);
      pin_in = 16'hA5A5;
      idle(2);
      cyc(1'b1, 4'd9, 16'h0000); rd(4'd9, v); chk("R6 clear after inactive", v, 16'h0000);
      cyc(1'b1, 4'd6, 16'hFFFD);
      rd(4'd9, v); chk("R6 not yet active low", v, 16'h0000);
      idle(1); rd(4'd9, v); chk("R6 active low latched", v, 16'h0002);
      cyc(1'b1, 4'd4, 16'hFFFF);
      cyc(1'b1, 4'd9, 16'h0000);

      // R11 unused and read-only addresses
      cyc(1'b1, 4'hF, 16'hFFFF);
      cyc(1'b1, 4'd3, 16'h5A5A);
      rd(4'hF, v); chk("R11 unused reads zero", v, 16'h0000);
      rd(4'd3, v); chk("R11 pin level unchanged", v, 16'hA5A5);
      rd(4'd0, v); chk("R11 direction unchanged", v, 16'h00F0);
      rd(4'd9, v); chk("R11 status unchanged", v, 16'h0000);

      // random mix against the bench model (R4-R10)
      for (int i = 0; i < 4000; i++) begin
         logic [3:0] a;
         pin_in = pin_in ^ ($urandom & $urandom & $urandom);
         if ($urandom_range(5) == 0) begin
            a = 4'($urandom_range(11));
            cyc(1'b1, a, 16'($urandom));
         end else begin
            idle(1);
         end
         chk("R8 random irq", {15'h0, irq_o}, {15'h0, |(m_st & ~m_im)});
         chk("R9 random wake", {15'h0, wake_o}, {15'h0, |(m_st & ~m_wm)});
         if (i % 8 == 0) begin
            rd(4'd9, v); chk("R10 random status", v, m_st);
            rd(4'd3, v); chk("R3 random pin level", v, m_s2);
         end
      end

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule